// File: doc/BRIEF.md
# Pausable Preemption Slice Timer

This block measures how much of its time allotment the running context has used, and asks the scheduler to switch contexts once that allotment runs out. A slice-duration register holds the allotment in cycles. Every completed context switch reloads a down-counter from that register. The counter then drops by one for each cycle in which the core runs user code. It does not move while the core runs in machine mode, runs in supervisor mode, runs a trap handler, or is saving or restoring context state.

When the count runs out, the block does not preempt at once. It waits for the next instruction boundary that the core reports while in plain user mode, and then raises a preempt request. The scheduler treats that request exactly like a voluntary yield. The request stays high until the next switch-complete pulse.

A duration of zero, which is also the value after reset, turns preemption off. In that case scheduling is purely cooperative.

Top module: `slice_timer`

## Requirements
- R1: After reset the preempt request is low and the duration is zero. Without a later write and reload, no amount of user-mode execution raises the request.
- R2: After a switch-complete pulse with a nonzero duration D loaded, the request rises at the clock edge that ends the D-th counted cycle, provided that cycle carries a user-mode instruction boundary. It stays low at every earlier edge.
- R3: A cycle counts only when machine mode, supervisor mode, trap handling and switch-in-progress are all low. Cycles in any of these states neither advance the count nor raise the request.
- R4: If a reload takes place while the duration is zero, the request stays low until the next reload, whatever the mode or boundary activity.
- R5: A switch-complete pulse loads the counter with the duration register value as it stood before that clock edge. A write in the same cycle applies from the following reload.
- R6: Once the count is exhausted, the request rises only at the edge after a cycle that has a boundary strobe outside every privileged and trap state. Exhaustion alone does not raise it, and neither does a boundary strobe during a trap. The first user-mode boundary after a trap return raises it.
- R7: Once raised, the request holds through any mode until a switch-complete pulse. That pulse clears it at the same edge, even if a boundary strobe arrives in that cycle.
- R8: Writing the duration register while a slice is running leaves the running count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dur_we_i | input | 1 | Write strobe for the slice-duration register |
| dur_wdata_i | input | CNT_W | New slice duration in cycles; zero disables preemption |
| mode_m_i | input | 1 | Core is executing in machine mode |
| mode_s_i | input | 1 | Core is executing in supervisor mode |
| in_trap_i | input | 1 | A trap handler is active and has not yet returned |
| sw_busy_i | input | 1 | A context save or restore is in progress |
| sw_done_i | input | 1 | One-cycle pulse when a context switch completes; reloads the counter and clears the request |
| insn_boundary_i | input | 1 | Strobe marking an instruction boundary in this cycle |
| preempt_o | output | 1 | Preempt request; to be handled like a yield |

## Verification
If the count is off by one, or if a paused cycle is wrongly counted, the preempt request rises one or more edges early or late relative to the hand-counted user cycles. The bench sees this within the slice under test. A wrong armed or expired flag shows up in one of two ways: either the request rises during a zero-duration interval, or it never rises after a trap return. The stimulus sequences are built so that each of these states must show at the request output within a few cycles of being entered. A request that clears early, or survives a switch, differs at the first edge after the relevant strobe.

// File: rtl/slice_timer_pkg.sv
package slice_timer_pkg;

    typedef struct packed {
        logic mach;
        logic sup;
        logic trap;
        logic swbusy;
    } run_mode_t;

    function automatic logic is_user(run_mode_t m);
        return !(m.mach || m.sup || m.trap || m.swbusy);
    endfunction

endpackage

// File: rtl/slice_run_gate.sv
module slice_run_gate
    import slice_timer_pkg::*;
(
    input  run_mode_t mode_i,
    input  logic      bnd_i,
    output logic      tick_o,
    output logic      user_bnd_o
);

    always_comb begin
        tick_o     = is_user(mode_i);
        user_bnd_o = tick_o && bnd_i;
    end

endmodule

// File: rtl/slice_dur_reg.sv
module slice_dur_reg #(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] dur_o,
    output logic             dur_nz_o
);

    typedef struct packed {
        logic [CNT_W-1:0] dur;
    } dur_state_t;

    dur_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.dur = wdata_i;
        end
        dur_o    = st_q.dur;
        dur_nz_o = |st_q.dur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/slice_down_cnt.sv
module slice_down_cnt #(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] dur_i,
    input  logic             dur_nz_i,
    input  logic             tick_i,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             expired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       counting;
    logic       last_tick;

    always_comb begin
        st_d      = st_q;
        counting  = !reload_i && tick_i && st_q.armed && !st_q.expired;
        last_tick = counting && (st_q.cnt == ONE);
        if (reload_i) begin
            st_d.cnt     = dur_i;
            st_d.armed   = dur_nz_i;
            st_d.expired = 1'b0;
        end else if (counting) begin
            st_d.cnt = st_q.cnt - ONE;
            if (last_tick) begin
                st_d.expired = 1'b1;
            end
        end
        expired_o = !reload_i && (st_q.expired || last_tick);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/slice_preempt_latch.sv
module slice_preempt_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic set_i,
    output logic req_o
);

    typedef struct packed {
        logic req;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.req = 1'b0;
        end else if (set_i) begin
            st_d.req = 1'b1;
        end
        req_o = st_q.req;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/slice_timer.sv
module slice_timer
    import slice_timer_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dur_we_i,
    input  logic [CNT_W-1:0] dur_wdata_i,
    input  logic             mode_m_i,
    input  logic             mode_s_i,
    input  logic             in_trap_i,
    input  logic             sw_busy_i,
    input  logic             sw_done_i,
    input  logic             insn_boundary_i,
    output logic             preempt_o
);

    run_mode_t        mode;
    logic             tick;
    logic             user_bnd;
    logic [CNT_W-1:0] dur;
    logic             dur_nz;
    logic             expired;
    logic             set_req;

    always_comb begin
        mode.mach   = mode_m_i;
        mode.sup    = mode_s_i;
        mode.trap   = in_trap_i;
        mode.swbusy = sw_busy_i;
        set_req     = expired && user_bnd;
    end

    slice_run_gate u_gate (
        .mode_i     (mode),
        .bnd_i      (insn_boundary_i),
        .tick_o     (tick),
        .user_bnd_o (user_bnd)
    );

    slice_dur_reg #(.CNT_W(CNT_W)) u_dur (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (dur_we_i),
        .wdata_i  (dur_wdata_i),
        .dur_o    (dur),
        .dur_nz_o (dur_nz)
    );

    slice_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reload_i  (sw_done_i),
        .dur_i     (dur),
        .dur_nz_i  (dur_nz),
        .tick_i    (tick),
        .expired_o (expired)
    );

    slice_preempt_latch u_req (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (sw_done_i),
        .set_i   (set_req),
        .req_o   (preempt_o)
    );

endmodule

// File: rtl/slice_timer_chk.sv
module slice_timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             dur_we_i,
    input logic [CNT_W-1:0] dur_wdata_i,
    input logic             mode_m_i,
    input logic             mode_s_i,
    input logic             in_trap_i,
    input logic             sw_busy_i,
    input logic             sw_done_i,
    input logic             insn_boundary_i,
    input logic             preempt_o
);

    logic             dur_nz_s;
    logic             arm_s;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dur_nz_s <= 1'b0;
            arm_s    <= 1'b0;
        end else begin
            if (sw_done_i) begin
                arm_s <= dur_nz_s;
            end
            if (dur_we_i) begin
                dur_nz_s <= |dur_wdata_i;
            end
        end
    end

    AST_PREEMPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preempt_o && !sw_done_i) |=> preempt_o); // R7

    AST_SWITCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_done_i |=> !preempt_o); // R7

    AST_RISE_ON_USER_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(preempt_o) |-> $past(insn_boundary_i && !mode_m_i && !mode_s_i && !in_trap_i)); // R6

    AST_NO_RISE_IN_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(preempt_o) |-> $past(!sw_busy_i && !sw_done_i)); // R3

    AST_ZERO_DUR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_s |-> !preempt_o); // R4

endmodule

bind slice_timer slice_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .dur_we_i        (dur_we_i),
    .dur_wdata_i     (dur_wdata_i),
    .mode_m_i        (mode_m_i),
    .mode_s_i        (mode_s_i),
    .in_trap_i       (in_trap_i),
    .sw_busy_i       (sw_busy_i),
    .sw_done_i       (sw_done_i),
    .insn_boundary_i (insn_boundary_i),
    .preempt_o       (preempt_o)
);

// File: tb/slice_timer_tb.sv
`timescale 1ns/1ps
module slice_timer_tb;

    localparam int CNT_W = 64;
    localparam int NV    = 32;

    // Vector layout: {we, wdata[15:0], m, s, trap, busy, done, bnd, exp, req[3:0]}
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 16'd3, 7'b0000000, 4'd5}, // R5 write 3
        {1'b0, 16'd0, 7'b0000100, 4'd5}, // R5 reload 3
        {1'b0, 16'd0, 7'b0000010, 4'd2}, // R2 3->2
        {1'b0, 16'd0, 7'b1000010, 4'd3}, // R3 machine mode pause
        {1'b0, 16'd0, 7'b0100010, 4'd3}, // R3 supervisor pause
        {1'b0, 16'd0, 7'b0001010, 4'd3}, // R3 switch busy pause
        {1'b0, 16'd0, 7'b0000010, 4'd2}, // R2 2->1
        {1'b0, 16'd0, 7'b0000011, 4'd2}, // R2 last tick, request
        {1'b0, 16'd0, 7'b0000001, 4'd7}, // R7 hold
        {1'b0, 16'd0, 7'b1000001, 4'd7}, // R7 hold in machine mode
        {1'b0, 16'd0, 7'b0000100, 4'd7}, // R7 cleared, reload 3
        {1'b1, 16'd5, 7'b0000010, 4'd8}, // R8 write 5 mid slice, 3->2
        {1'b0, 16'd0, 7'b0000010, 4'd8}, // R8 2->1
        {1'b0, 16'd0, 7'b0000011, 4'd8}, // R8 old count expires
        {1'b0, 16'd0, 7'b0000100, 4'd5}, // R5 reload 5
        {1'b0, 16'd0, 7'b0000010, 4'd2},
        {1'b0, 16'd0, 7'b0000010, 4'd2},
        {1'b0, 16'd0, 7'b0000010, 4'd2},
        {1'b0, 16'd0, 7'b0000010, 4'd2}, // count now 1
        {1'b0, 16'd0, 7'b0000000, 4'd6}, // R6 expires without boundary
        {1'b0, 16'd0, 7'b0010010, 4'd6}, // R6 boundary inside trap
        {1'b0, 16'd0, 7'b0000011, 4'd6}, // R6 first user boundary
        {1'b0, 16'd0, 7'b0000110, 4'd7}, // R7 done beats boundary
        {1'b1, 16'd0, 7'b1000000, 4'd4}, // R4 write zero
        {1'b0, 16'd0, 7'b0000100, 4'd4}, // R4 reload zero
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4},
        {1'b0, 16'd0, 7'b0000010, 4'd4}
    };

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             dur_we_i = 1'b0;
    logic [CNT_W-1:0] dur_wdata_i = '0;
    logic             mode_m_i = 1'b0;
    logic             mode_s_i = 1'b0;
    logic             in_trap_i = 1'b0;
    logic             sw_busy_i = 1'b0;
    logic             sw_done_i = 1'b0;
    logic             insn_boundary_i = 1'b0;
    logic             preempt_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #2 clk_i = ~clk_i;

    slice_timer #(.CNT_W(CNT_W)) u_dut (.*);

    task automatic check(input logic exp, input int req, input string what);
        checks++;
        if (preempt_o !== exp) begin
            failures++;
            $display("FAIL R%0d %s: preempt_o=%b expected=%b", req, what, preempt_o, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [15:0] wd, input logic m, input logic s,
                         input logic tr, input logic bs, input logic dn, input logic bd);
        dur_we_i        = we;
        dur_wdata_i     = CNT_W'(wd);
        mode_m_i        = m;
        mode_s_i        = s;
        in_trap_i       = tr;
        sw_busy_i       = bs;
        sw_done_i       = dn;
        insn_boundary_i = bd;
        @(negedge clk_i);
    endtask

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 100000 && !done_flag) begin
            done_flag = 1'b1;
            failures++;
            $display("FAIL watchdog expired: cycles=%0d expected below 100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check(1'b0, 1, "R1 reset value");
        rst_ni = 1'b1;
        // R1: default duration zero, no reload: never preempts
        for (int i = 0; i < 10; i++) begin
            drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            check(1'b0, 1, "R1 cooperative default");
        end

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            drive(v[27], v[26:11], v[10], v[9], v[8], v[7], v[6], v[5]);
            check(v[4], int'(v[3:0]), $sformatf("vector %0d", i));
        end

        // R2: duration of one
        drive(1'b1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(1'b0, 2, "R2 D=1 after reload");
        drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check(1'b1, 2, "R2 D=1 first user boundary");
        // R7: hold through trap and supervisor, then clear
        drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check(1'b1, 7, "R7 hold in trap");
        drive(1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check(1'b1, 7, "R7 hold during switch");
        drive(1'b1, 16'd200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(1'b0, 7, "R7 clear on done");

        // R2: longer slice (old duration 1 was reloaded; reload again to take 200)
        drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 1; i < 200; i++) begin
            drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            if (i == 199) check(1'b0, 2, "R2 D=200 one cycle early");
        end
        drive(1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check(1'b1, 2, "R2 D=200 exact");

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule